// File: doc/BRIEF.md
# Prioritized Interrupt Bank Controller

This block gathers a bank of interrupt request lines and presents two processor-facing outputs: a normal interrupt (`irq_o`) and a fast interrupt (`fiq_o`). Every source has its own small configuration word. The word holds a priority, a choice between edge and level sensing, and a routing bit that sends the source to the fast output instead of the normal one. Incoming requests are latched into a pending vector. The lowest-numbered priority among unmasked pending sources is chosen for each output. That winner is frozen and its number can be read back until software acknowledges it.

Software reaches the block through a plain register bus: a one-cycle write strobe with address and data, and a combinational read port. The mask, pending, winner and global-mask registers sit at fixed word offsets. The per-source configuration words start at offset 0x80, one word per source, 4 bytes apart. A parameter marks the instance as the first bank of a chain. Only the first bank may route sources to the fast output. In any other bank the routing bit is held at zero and the fast-output arbiter is not built.

Top module: `irq_bank_ctrl`

## Requirements
- R1: After reset, the mask register (0x00) reads all ones, the pending register (0x04) reads zero, the global mask (0x14) reads 1, and both outputs are low.
- R2: A 1 in bit n of the mask register keeps source n from winning either output, while its pending bit still records the request. Clearing the bit lets the source win.
- R3: The configuration word of source n is at byte offset 0x80 + 4*n. Bit 0 routes the source to the fast output, bit 1 selects level sensing when 1 and edge sensing when 0, and bits 6:2 hold the priority. The word reads back as written.
- R4: For an edge source, a rising edge on its line sets its pending bit. The bit stays set after the line falls, until that source is acknowledged as a winner.
- R5: For a level source, the pending bit follows the line one clock later. Acknowledging it while the line is still high lets it win again.
- R6: Among candidates, the lower priority value wins. When priorities are equal, the lower source index wins.
- R7: A winner is captured one clock after it becomes a candidate and is held, unchanged by new requests, until acknowledged. The normal winner reads at 0x08 and the fast winner at 0x0C, each with bit 31 = valid and bits 4:0 = source index.
- R8: Writing the control register (0x10) with bit 0 set acknowledges the normal winner, and with bit 1 set acknowledges the fast winner; 0x3 acknowledges both. The acknowledged output drops in the next cycle, an edge winner's pending bit is cleared, and arbitration resumes one clock later.
- R9: While the global mask (0x14, bit 0) is 1, both outputs stay low but held winners are kept. Writing 0 lets them through.
- R10: Sources whose routing bit is 1 compete only for the fast output; the others compete only for the normal output.
- R11: When the first-bank parameter is 0, the routing bit always reads back 0 and the fast output never asserts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_line_i | input | NSRC | Interrupt request lines |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i |
| irq_o | output | 1 | Normal interrupt to the processor |
| fiq_o | output | 1 | Fast interrupt to the processor |

## Verification
Single-source pulses are swept across all 32 lines, so that each index reaches the winner register and is acknowledged cleanly; this separates index and decode faults from arbitration faults. Firing all lines at once with a priority permutation checks that winners appear in strictly ascending priority. A tie between two sources separates the tie-break from the priority compare. Targeted patterns cover masking, level sensing while the line stays high, a late high-priority arrival against a frozen winner, global masking, fast-output routing with separate acknowledges, and a second instance built as a non-first bank.

// File: rtl/irqb_pkg.sv
package irqb_pkg;
    localparam int OFS_MASK   = 'h00;
    localparam int OFS_PEND   = 'h04;
    localparam int OFS_IRQSRC = 'h08;
    localparam int OFS_FIQSRC = 'h0C;
    localparam int OFS_CTRL   = 'h10;
    localparam int OFS_GMASK  = 'h14;
    localparam int OFS_LVL    = 'h80;
    localparam int CFG_FIQ_BIT  = 0;
    localparam int CFG_TRIG_BIT = 1;
    localparam int CFG_PRIO_LSB = 2;
    localparam int SRC_VALID_BIT = 31;
endpackage

// File: rtl/irqb_pend.sv
module irqb_pend #(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] line_i,
    input  logic [NSRC-1:0] level_i,
    input  logic [NSRC-1:0] clr_i,
    output logic [NSRC-1:0] pend_o
);
    typedef struct packed {
        logic [NSRC-1:0] prev;
        logic [NSRC-1:0] pend;
    } pend_st_t;

    pend_st_t st_d, st_q;
    logic [NSRC-1:0] rise;

    always_comb begin
        st_d      = st_q;
        st_d.prev = line_i;
        rise      = line_i & ~st_q.prev;
        for (int i = 0; i < NSRC; i++) begin
            if (level_i[i]) begin
                st_d.pend[i] = line_i[i];
            end else begin
                st_d.pend[i] = (st_q.pend[i] & ~clr_i[i]) | rise[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;

    AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        ((line_i & ~st_q.prev & ~level_i) != '0) |=>
        (!$stable(level_i) || (($past(line_i & ~st_q.prev & ~level_i) & ~pend_o) == '0))); // R4

    AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_o & ~level_i & ~clr_i) != '0) |=>
        (!$stable(level_i) || (($past(pend_o & ~level_i & ~clr_i) & ~pend_o) == '0))); // R4
endmodule

// File: rtl/irqb_arb.sv
module irqb_arb #(
    parameter int NSRC   = 32,
    parameter int PRIO_W = 5,
    localparam int IDX_W = $clog2(NSRC)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NSRC-1:0]               cand_i,
    input  logic [NSRC-1:0][PRIO_W-1:0]   prio_i,
    input  logic                          ack_i,
    output logic                          held_o,
    output logic [IDX_W-1:0]              idx_o
);
    typedef struct packed {
        logic             held;
        logic [IDX_W-1:0] idx;
    } arb_st_t;

    arb_st_t st_d, st_q;
    logic              found;
    logic [PRIO_W-1:0] best_p;
    logic [IDX_W-1:0]  best_i;

    always_comb begin
        found  = 1'b0;
        best_p = '0;
        best_i = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (cand_i[i] && (!found || prio_i[i] <= best_p)) begin
                found  = 1'b1;
                best_p = prio_i[i];
                best_i = IDX_W'(i);
            end
        end
        st_d = st_q;
        if (st_q.held) begin
            if (ack_i) begin
                st_d.held = 1'b0;
            end
        end else if (found) begin
            st_d.held = 1'b1;
            st_d.idx  = best_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign held_o = st_q.held;
    assign idx_o  = st_q.idx;

    AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (!held_o && (cand_i != '0)) |=> held_o); // R7

    AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (held_o && !ack_i) |=> (held_o && $stable(idx_o))); // R7

    AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (held_o && ack_i) |=> !held_o); // R8
endmodule

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
    import irqb_pkg::*;
#(
    parameter int NSRC      = 32,
    parameter int PRIO_W    = 5,
    parameter int ADDR_W    = 8,
    parameter bit BANK_ZERO = 1'b1,
    localparam int IDX_W    = $clog2(NSRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   irq_line_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    output logic              irq_o,
    output logic              fiq_o
);
    localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(OFS_MASK);
    localparam logic [ADDR_W-1:0] A_PEND   = ADDR_W'(OFS_PEND);
    localparam logic [ADDR_W-1:0] A_IRQSRC = ADDR_W'(OFS_IRQSRC);
    localparam logic [ADDR_W-1:0] A_FIQSRC = ADDR_W'(OFS_FIQSRC);
    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_GMASK  = ADDR_W'(OFS_GMASK);
    localparam logic [ADDR_W-1:0] A_LVL    = ADDR_W'(OFS_LVL);
    localparam int LVL_END = OFS_LVL + 4 * NSRC;

    typedef struct packed {
        logic [NSRC-1:0]             mask;
        logic                        gmask;
        logic [NSRC-1:0]             fiq_sel;
        logic [NSRC-1:0]             lvl;
        logic [NSRC-1:0][PRIO_W-1:0] prio;
    } cfg_st_t;

    cfg_st_t cfg_d, cfg_q;

    logic [ADDR_W-1:0] lvl_off;
    logic [IDX_W-1:0]  lvl_idx;
    logic              lvl_hit;
    logic              ack_irq, ack_fiq;
    logic [NSRC-1:0]   pend, cand_irq, cand_fiq, clr;
    logic              irq_held, fiq_held;
    logic [IDX_W-1:0]  irq_idx, fiq_idx;

    always_comb begin
        lvl_off = bus_addr_i - A_LVL;
        lvl_idx = lvl_off[IDX_W+1:2];
        lvl_hit = (int'(bus_addr_i) >= OFS_LVL) && (int'(bus_addr_i) < LVL_END);
        ack_irq = bus_we_i && (bus_addr_i == A_CTRL) && bus_wdata_i[0];
        ack_fiq = bus_we_i && (bus_addr_i == A_CTRL) && bus_wdata_i[1];

        cfg_d = cfg_q;
        if (bus_we_i) begin
            if (bus_addr_i == A_MASK) begin
                cfg_d.mask = bus_wdata_i[NSRC-1:0];
            end
            if (bus_addr_i == A_GMASK) begin
                cfg_d.gmask = bus_wdata_i[0];
            end
            if (lvl_hit) begin
                cfg_d.fiq_sel[lvl_idx] = BANK_ZERO & bus_wdata_i[CFG_FIQ_BIT];
                cfg_d.lvl[lvl_idx]     = bus_wdata_i[CFG_TRIG_BIT];
                cfg_d.prio[lvl_idx]    = bus_wdata_i[CFG_PRIO_LSB +: PRIO_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q       <= '0;
            cfg_q.mask  <= '1;
            cfg_q.gmask <= 1'b1;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        cand_irq = pend & ~cfg_q.mask & ~cfg_q.fiq_sel;
        cand_fiq = pend & ~cfg_q.mask & cfg_q.fiq_sel;
        clr = '0;
        if (ack_irq && irq_held) clr = clr | (NSRC'(1) << irq_idx);
        if (ack_fiq && fiq_held) clr = clr | (NSRC'(1) << fiq_idx);
    end

    irqb_pend #(.NSRC(NSRC)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_i  (irq_line_i),
        .level_i (cfg_q.lvl),
        .clr_i   (clr),
        .pend_o  (pend)
    );

    irqb_arb #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_arb_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .cand_i (cand_irq),
        .prio_i (cfg_q.prio),
        .ack_i  (ack_irq),
        .held_o (irq_held),
        .idx_o  (irq_idx)
    );

    generate
        if (BANK_ZERO) begin : g_fiq
            irqb_arb #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_arb_fiq (
                .clk    (clk),
                .rst_n  (rst_n),
                .cand_i (cand_fiq),
                .prio_i (cfg_q.prio),
                .ack_i  (ack_fiq),
                .held_o (fiq_held),
                .idx_o  (fiq_idx)
            );
        end else begin : g_nofiq
            assign fiq_held = 1'b0;
            assign fiq_idx  = '0;
        end
    endgenerate

    assign irq_o = irq_held & ~cfg_q.gmask;
    assign fiq_o = fiq_held & ~cfg_q.gmask;

    always_comb begin
        bus_rdata_o = '0;
        if (lvl_hit) begin
            bus_rdata_o = 32'({cfg_q.prio[lvl_idx], cfg_q.lvl[lvl_idx], cfg_q.fiq_sel[lvl_idx]});
        end else begin
            case (bus_addr_i)
                A_MASK:   bus_rdata_o = 32'(cfg_q.mask);
                A_PEND:   bus_rdata_o = 32'(pend);
                A_IRQSRC: begin
                    bus_rdata_o[SRC_VALID_BIT] = irq_held;
                    bus_rdata_o[IDX_W-1:0]     = irq_idx;
                end
                A_FIQSRC: begin
                    bus_rdata_o[SRC_VALID_BIT] = fiq_held;
                    bus_rdata_o[IDX_W-1:0]     = fiq_idx;
                end
                A_GMASK:  bus_rdata_o = 32'(cfg_q.gmask);
                default:  bus_rdata_o = '0;
            endcase
        end
    end

    AST_NOFIQ_OTHER_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (!BANK_ZERO) |-> (!fiq_o && (cfg_q.fiq_sel == '0))); // R11

    AST_MASKED_NOT_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_held && (cand_irq == '0)) |=> !irq_held); // R2
endmodule

// File: tb/sim_irq_bank_ctrl.sv
module sim_irq_bank_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] line = '0;
    logic        we = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata0, rdata1;
    logic        irq0, fiq0, irq1, fiq1;
    int          total = 0;
    int          bad = 0;
    bit          done = 0;

    always #10 clk = ~clk;

    irq_bank_ctrl #(.BANK_ZERO(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .irq_line_i(line), .bus_we_i(we),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata0),
        .irq_o(irq0), .fiq_o(fiq0));

    irq_bank_ctrl #(.BANK_ZERO(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .irq_line_i(line), .bus_we_i(we),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata1),
        .irq_o(irq1), .fiq_o(fiq1));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse(input logic [31:0] m);
        @(negedge clk);
        line = m;
        @(negedge clk);
        line = '0;
    endtask

    function automatic logic [31:0] cfgw(input int prio, input bit trig, input bit fq);
        return 32'((prio << 2) | (int'(trig) << 1) | int'(fq));
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(8'h00, v); chk("R1 mask", v, 32'hFFFF_FFFF);
        rd(8'h04, v); chk("R1 pend", v, 32'h0);
        rd(8'h14, v); chk("R1 gmask", v, 32'h1);
        chk("R1 outs", {30'b0, irq0, fiq0}, 32'h0);

        // R3 / R11 configuration word sweep
        for (int i = 0; i < 32; i++)
            wr(8'(8'h80 + 4 * i), cfgw((i * 7) % 32, i[0], i[1]));
        for (int i = 0; i < 32; i++) begin
            rd(8'(8'h80 + 4 * i), v);
            chk("R3 cfg readback", v, cfgw((i * 7) % 32, i[0], i[1]));
            #1;
            chk("R11 nonzero bank fiq bit", rdata1, cfgw((i * 7) % 32, i[0], 1'b0));
        end

        // edge sources, priority permutation, normal output only
        for (int i = 0; i < 32; i++) wr(8'(8'h80 + 4 * i), cfgw((i * 13) % 32, 1'b0, 1'b0));
        wr(8'h00, 32'h0);
        wr(8'h14, 32'h0);

        // single-source sweep
        for (int i = 0; i < 32; i++) begin
            pulse(32'h1 << i);
            settle();
            rd(8'h04, v); chk("R4 sticky pend", v, 32'h1 << i);
            chk("R7 irq out", {31'b0, irq0}, 32'h1);
            rd(8'h08, v); chk("R7 src", v, 32'h8000_0000 | i);
            wr(8'h10, 32'h1);
            chk("R8 irq drops", {31'b0, irq0}, 32'h0);
            settle();
            rd(8'h04, v); chk("R8 pend cleared", v, 32'h0);
        end

        // all at once: ascending priority order
        pulse('1);
        settle();
        for (int k = 0; k < 32; k++) begin
            int exp_i = 0;
            for (int j = 0; j < 32; j++) if ((j * 13) % 32 == k) exp_i = j;
            rd(8'h08, v); chk("R6 priority order", v, 32'h8000_0000 | exp_i);
            wr(8'h10, 32'h1);
            settle();
        end
        chk("R8 all served", {31'b0, irq0}, 32'h0);

        // tie: equal priority, lower index wins
        wr(8'h80 + 4 * 9, cfgw(5, 0, 0));
        wr(8'h80 + 4 * 20, cfgw(5, 0, 0));
        pulse((32'h1 << 9) | (32'h1 << 20));
        settle();
        rd(8'h08, v); chk("R6 tie low index", v, 32'h8000_0009);
        wr(8'h10, 32'h1); settle();
        rd(8'h08, v); chk("R6 tie second", v, 32'h8000_0014);
        wr(8'h10, 32'h1); settle();

        // freeze: late higher-priority source does not displace winner
        wr(8'h80 + 4 * 2, cfgw(10, 0, 0));
        wr(8'h80 + 4 * 3, cfgw(0, 0, 0));
        pulse(32'h4); settle();
        pulse(32'h8); settle();
        rd(8'h08, v); chk("R7 frozen winner", v, 32'h8000_0002);
        wr(8'h10, 32'h1); settle();
        rd(8'h08, v); chk("R8 rearbitrate", v, 32'h8000_0003);
        wr(8'h10, 32'h1); settle();

        // mask
        wr(8'h00, 32'h8);
        pulse(32'h8); settle();
        chk("R2 masked no irq", {31'b0, irq0}, 32'h0);
        rd(8'h04, v); chk("R2 masked pending", v, 32'h8);
        wr(8'h00, 32'h0); settle();
        rd(8'h08, v); chk("R2 unmasked wins", v, 32'h8000_0003);
        wr(8'h10, 32'h1); settle();

        // level source
        wr(8'h80 + 4 * 7, cfgw(1, 1, 0));
        @(negedge clk); line = 32'h80;
        settle();
        rd(8'h08, v); chk("R5 level wins", v, 32'h8000_0007);
        wr(8'h10, 32'h1); settle();
        rd(8'h08, v); chk("R5 level rewins", v, 32'h8000_0007);
        chk("R5 irq again", {31'b0, irq0}, 32'h1);

        // global mask keeps winner
        wr(8'h14, 32'h1);
        chk("R9 gmask blocks", {31'b0, irq0}, 32'h0);
        rd(8'h08, v); chk("R9 winner kept", v, 32'h8000_0007);
        wr(8'h14, 32'h0);
        chk("R9 gmask released", {31'b0, irq0}, 32'h1);
        @(negedge clk); line = '0;
        @(negedge clk);
        wr(8'h10, 32'h1); settle();
        rd(8'h04, v); chk("R5 level low pend", v, 32'h0);

        // fast routing
        wr(8'h80 + 4 * 4, cfgw(3, 0, 1));
        wr(8'h80 + 4 * 6, cfgw(3, 0, 0));
        pulse(32'h50); settle();
        rd(8'h0C, v); chk("R10 fiq src", v, 32'h8000_0004);
        rd(8'h08, v); chk("R10 irq src", v, 32'h8000_0006);
        chk("R10 outs", {30'b0, irq0, fiq0}, 32'h3);
        chk("R11 other bank no fiq", {30'b0, irq1, fiq1}, 32'h2);
        wr(8'h10, 32'h2);
        chk("R8 fiq-only ack", {30'b0, irq0, fiq0}, 32'h2);
        pulse(32'h10); settle();
        chk("R8 fiq again", {30'b0, irq0, fiq0}, 32'h3);
        wr(8'h10, 32'h3);
        chk("R8 both ack", {30'b0, irq0, fiq0}, 32'h0);
        settle();
        rd(8'h04, v); chk("R8 both pend cleared", v, 32'h0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule